// File: doc/BRIEF.md
# Local Countdown Timer with Line-Select Entry

This block is a 32-bit down-counting timer that sits next to a fixed-priority interrupt controller. Software programs it through a simple 32-bit register bus. The bus has three registers: a control entry, a start-count register and a read-only live-count register. When the live count runs out, the timer produces a one-cycle expiry pulse. If the timer is not masked, it also produces a request strobe. It always presents the number of the controller input line it drives.

The control entry does not hold a programmable vector. It holds a 4-bit line number, so the timer shares one of the sixteen lowest fixed-priority controller inputs. The timer runs either once or repeatedly. Writing a zero start count stops it. Writing a new start count while it runs restarts the countdown from the new value. Clock division, arbitration between lines and power-state save or restore belong to other blocks.

Top module: `lvt_tick_timer`

## Requirements
- R1: After reset, the control entry (offset 0x320) reads 0x0001_0000 (mask set, one-shot, line 0). The start count (0x380) and the live count (0x390) read 0, and neither the pulse nor the request is high.
- R2: In the control entry, bits 3:0 hold the line number, bit 16 is the mask and bit 17 selects repeat mode (1) over one-shot (0). All other bits read 0. Output `irq_line` always equals bits 3:0.
- R3: A write to 0x380 loads the value into both the start count and the live count at that clock edge. After that, the live count drops by one on each clock while the live count and the start count are both non-zero.
- R4: In one-shot mode, `expire_pulse` is high for exactly the one cycle in which the live count has just become 0 from 1. The count then stays at 0 with no further pulse.
- R5: In repeat mode, at the edge where the live count would go from 1 to 0, it reloads the start count instead and pulses. For a start count N, the pulses come every N cycles.
- R6: `irq_req` equals `expire_pulse` while mask bit 16 is 0, and stays low while that bit is 1. The pulse itself is not affected by the mask.
- R7: Writing 0 to 0x380 stops the timer at once. The live count reads 0 and no pulse follows in either mode.
- R8: A write to 0x380 while counting discards the remaining count and starts again from the new value.
- R9: The live count at 0x390 is read-only. A bus write to 0x390 changes neither count. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| expire_pulse | output | 1 | One-cycle pulse on count expiry, ignores mask |
| irq_req | output | 1 | Expiry pulse with the mask applied, for the controller |
| irq_line | output | 4 | Controller line the request is meant for |

## Verification
The hardest situations to reach are the boundaries where expiry, reload and a restart write meet. These include repeat mode with a start count of 1, which pulses every cycle, and a restart written while the count is partway down. The bench sweeps every start count from 1 to 5 in both modes with the mask set and clear. Each pass checks the live count and the pulse on every cycle for three periods, against a count computed arithmetically. A restart write is then placed in the middle of a countdown, followed by a zero write.

// File: rtl/lvt_tick_pkg.sv
// Shared constants and widths for the local countdown timer.
package lvt_tick_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned LINE_W  = 4;
    localparam int unsigned MASK_BIT = 16;
    localparam int unsigned REPEAT_BIT = 17;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h320;
    localparam logic [ADDR_W-1:0] OFS_START = 12'h380;
    localparam logic [ADDR_W-1:0] OFS_LIVE  = 12'h390;
endpackage

// File: rtl/lvt_tick_regs.sv
// Register file for the timer: the control entry and the start count, plus
// the read mux. Assumes single-cycle writes and a combinational read path.
module lvt_tick_regs
    import lvt_tick_pkg::*;
#(
    parameter int unsigned CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  start_cnt,
    output logic              load_stb,
    output logic [LINE_W-1:0] line_sel,
    output logic              masked,
    output logic              repeat_mode
);
    assign load_stb = bus_wr && (bus_addr == OFS_START);

    // Control entry: line number, mask (set at reset) and mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_sel    <= '0;
            masked      <= 1'b1;
            repeat_mode <= 1'b0;
        end else if (bus_wr && bus_addr == OFS_CTRL) begin
            line_sel    <= bus_wdata[LINE_W-1:0];
            masked      <= bus_wdata[MASK_BIT];
            repeat_mode <= bus_wdata[REPEAT_BIT];
        end
    end

    // Start count register, written by software at the start offset.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_cnt <= '0;
        else if (load_stb) start_cnt <= bus_wdata[CNT_W-1:0];
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[LINE_W-1:0] = line_sel;
                bus_rdata[MASK_BIT]   = masked;
                bus_rdata[REPEAT_BIT] = repeat_mode;
            end
            OFS_START: bus_rdata[CNT_W-1:0] = start_cnt;
            OFS_LIVE:  bus_rdata[CNT_W-1:0] = live_cnt;
            default:   bus_rdata = '0;
        endcase
    end

    // R9
    live_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LIVE) |=> $stable(start_cnt));
endmodule

// File: rtl/lvt_tick_counter.sv
// Down counter with one-shot and repeat modes. It loads on a start write,
// decrements while both counts are non-zero and emits a registered pulse in
// the cycle that follows the expiring edge.
module lvt_tick_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             repeat_mode,
    output logic [CNT_W-1:0] live_cnt,
    output logic             expire_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic running;
    logic at_end;
    assign running = (live_cnt != '0) && (start_cnt != '0);
    assign at_end  = running && (live_cnt == ONE);

    // Live count: load, reload on expiry in repeat mode, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                      live_cnt <= '0;
        else if (load_stb)               live_cnt <= load_val;
        else if (at_end && repeat_mode)  live_cnt <= start_cnt;
        else if (running)                live_cnt <= live_cnt - ONE;
    end

    // Expiry pulse, suppressed when a start write overrides the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) expire_pulse <= 1'b0;
        else        expire_pulse <= at_end && !load_stb;
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt > ONE && start_cnt != '0 && !load_stb) |=> live_cnt == $past(live_cnt) - ONE);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_cnt <= start_cnt);
    // R4
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!repeat_mode && live_cnt == '0 && !load_stb) |=> (live_cnt == '0 && !expire_pulse));
    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_pulse && start_cnt != ONE) |=> !expire_pulse);
    // R7
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cnt == '0) |-> (live_cnt == '0));
endmodule

// File: rtl/lvt_tick_timer.sv
// Top of the local countdown timer: register file, counter and the mask
// gate toward the interrupt controller. Assumes the companion controller
// takes a one-cycle request strobe together with a line number.
module lvt_tick_timer
    import lvt_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              expire_pulse,
    output logic              irq_req,
    output logic [LINE_W-1:0] irq_line
);
    localparam int unsigned CNT_W = DATA_W;

    logic [CNT_W-1:0] start_cnt;
    logic [CNT_W-1:0] live_cnt;
    logic             load_stb;
    logic             masked;
    logic             repeat_mode;

    lvt_tick_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .live_cnt(live_cnt), .bus_rdata(bus_rdata),
        .start_cnt(start_cnt), .load_stb(load_stb), .line_sel(irq_line),
        .masked(masked), .repeat_mode(repeat_mode)
    );

    lvt_tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb),
        .load_val(bus_wdata[CNT_W-1:0]), .start_cnt(start_cnt),
        .repeat_mode(repeat_mode), .live_cnt(live_cnt),
        .expire_pulse(expire_pulse)
    );

    // Mask gate: only unmasked expiries reach the controller.
    assign irq_req = expire_pulse && !masked;

    // R6
    req_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> expire_pulse);
    // R6
    mask_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[MASK_BIT] && bus_addr == OFS_CTRL) |-> !irq_req);
endmodule

// File: tb/lvt_tick_timer_bench.sv
module lvt_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        expire_pulse, irq_req;
    logic [3:0]  irq_line;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    lvt_tick_timer u_lvt_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .expire_pulse(expire_pulse), .irq_req(irq_req), .irq_line(irq_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 12'h390;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = 12'h390;
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_check("R1 ctrl", 12'h320, 32'h0001_0000);
        rd_check("R1 start", 12'h380, 32'h0);
        rd_check("R1 live", 12'h390, 32'h0);
        check("R1 pulse", {31'b0, expire_pulse}, 32'h0);
        check("R1 req", {31'b0, irq_req}, 32'h0);

        // R2 field layout and line output for every line number
        wr(12'h320, 32'hFFFF_FFFF);
        rd_check("R2 ctrl all ones", 12'h320, 32'h0003_000F);
        for (int l = 0; l < 16; l++) begin
            wr(12'h320, 32'h0001_0000 | l);
            check("R2 irq_line", {28'b0, irq_line}, l);
            rd_check("R2 ctrl line", 12'h320, 32'h0001_0000 | l);
        end

        // R3 R4 R5 R6 sweep over mode, mask and start count
        for (int per = 0; per < 2; per++) begin
            for (int msk = 0; msk < 2; msk++) begin
                for (int v = 1; v <= 5; v++) begin
                    wr(12'h320, (per << 17) | (msk << 16) | (v + 7));
                    wr(12'h380, v);
                    rd_check("R3 live after load", 12'h390, v);
                    for (int n = 1; n <= 3 * v + 2; n++) begin
                        int ec;
                        int ep;
                        @(negedge clk);
                        #1;
                        if (per == 1) begin
                            ec = v - (n % v);
                            ep = ((n % v) == 0) ? 1 : 0;
                            check("R5 live", bus_rdata, ec);
                            check("R5 pulse", {31'b0, expire_pulse}, ep);
                        end else begin
                            ec = (n >= v) ? 0 : v - n;
                            ep = (n == v) ? 1 : 0;
                            check("R4 live", bus_rdata, ec);
                            check("R4 pulse", {31'b0, expire_pulse}, ep);
                        end
                        check("R6 req", {31'b0, irq_req}, (msk == 0) ? ep : 0);
                        check("R2 line", {28'b0, irq_line}, v + 7);
                    end
                end
            end
        end

        // R8 restart mid-count in one-shot, unmasked
        wr(12'h320, 32'h0000_0003);
        wr(12'h380, 10);
        repeat (4) @(negedge clk);
        #1 check("R8 partway", bus_rdata, 6);
        wr(12'h380, 3);
        #1 check("R8 reloaded", bus_rdata, 3);
        for (int n = 1; n <= 8; n++) begin
            @(negedge clk);
            #1;
            check("R8 live", bus_rdata, (n >= 3) ? 0 : 3 - n);
            check("R8 req", {31'b0, irq_req}, (n == 3) ? 1 : 0);
        end

        // R9 write to live offset ignored
        wr(12'h320, 32'h0002_0000);
        wr(12'h380, 20);
        wr(12'h390, 32'h0000_0005);
        #1 check("R9 live unaffected", bus_rdata, 18);
        rd_check("R9 start unaffected", 12'h380, 20);
        rd_check("R9 unmapped", 12'h100, 0);

        // R7 zero write stops repeat timer
        wr(12'h380, 0);
        #1 check("R7 live zero", bus_rdata, 0);
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            #1;
            check("R7 no pulse", {31'b0, expire_pulse}, 0);
            check("R7 stays zero", bus_rdata, 0);
        end

        // R5 repeat with start count 1 pulses each cycle
        wr(12'h380, 1);
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            #1 check("R5 every cycle", {31'b0, expire_pulse}, 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule